// File: doc/BRIEF.md
# Interrupt Redirection Register Interface

This block is the indirectly addressed register front end of an I/O interrupt routing controller. A 32-bit slave port reaches three locations inside a 256-byte window: an index-select register, a data window, and an end-of-interrupt (EOI) register. The value held in the select register decides what the data window shows. It can show the controller identification word, the version word, the arbitration word, or one 32-bit half of a 64-bit redirection entry for any of the input pins.

Each redirection entry has read/write fields that software sets: vector, delivery mode, destination mode, polarity, trigger mode, mask and destination. It also has two status bits that only the service logic may change: delivery status and remote IRR. A write through the window updates the read/write fields and leaves the status bits as they were. When the write leaves an entry in edge trigger mode, its remote IRR bit is cleared. Every table write raises a one-cycle request for a service pass. Full-word writes to the EOI register send a vector to the service logic, but only when the block is built as version 0x20. The whole table is presented on a flat output bus.

Top module: `irq_redir_regif`

## Requirements
- R1: The port carries an 8-bit byte offset. Select sits at offset 0x00, the data window at 0x10 and EOI at 0x40. A read (rdEn) loads rdData on the next clock edge. Reads of any other offset, EOI included, return zero.
- R2: The select register is 8 bits wide. A write to offset 0x00 with byte lane 0 enabled loads it from wrData[7:0]. Reading offset 0x00 returns it zero-extended. Its reset value is 0.
- R3: When select is 0x00 (identification) or 0x02 (arbitration), the window reads as ctrlId placed in bits 27:24, with all other bits zero.
- R4: When select is 0x01, the window reads as VERSION in bits 7:0 ORed with (NUM_PINS − 1) in bits 23:16. VERSION must be 0x11 or 0x20.
- R5: Select values 0x10 + 2n and 0x10 + 2n + 1 reach the lower and upper 32 bits of entry n. Writes honour byteEn per lane. Entry n appears on tableOut[64n +: 64].
- R6: Entry bit 12 (delivery status) and bit 14 (remote IRR) keep their previous values across window writes. They change only through the pendSet/pendClr and remIrrSet/remIrrClr inputs, and set wins over clear.
- R7: After a window write to an entry, if its bit 15 (trigger, 1 = level) is 0, its remote IRR bit reads 0. Writes to level-triggered entries leave remote IRR unchanged.
- R8: A write to EOI with all four byte lanes enabled pulses eoiStrobe for one cycle, with eoiVector = wrData[7:0], on the edge after the write. This happens only when VERSION is 0x20. Partial-word writes, and any write on a 0x11 build, are ignored.
- R9: serviceReq pulses for one cycle after each window write that reaches an in-range entry, and at no other time.
- R10: After reset every entry holds only bit 16 (mask) set, that is 0x00000000_00010000.
- R11: A select that reaches no register or entry (index ≥ NUM_PINS, 0x03 to 0x0F) reads as zero through the window. A window write there changes no entry and raises no service request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | 8 | Byte offset inside the register window |
| wrEn | input | 1 | Write request this cycle |
| rdEn | input | 1 | Read request this cycle |
| byteEn | input | 4 | Byte lane enables for writes |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, valid the cycle after rdEn |
| ctrlId | input | 4 | Controller identification value |
| pendSet | input | NUM_PINS | Set delivery status per entry |
| pendClr | input | NUM_PINS | Clear delivery status per entry |
| remIrrSet | input | NUM_PINS | Set remote IRR per entry |
| remIrrClr | input | NUM_PINS | Clear remote IRR per entry |
| tableOut | output | 64*NUM_PINS | Flattened redirection table |
| serviceReq | output | 1 | One-cycle request for a service pass |
| eoiStrobe | output | 1 | One-cycle EOI pulse |
| eoiVector | output | 8 | Vector carried by the EOI pulse |

## Verification
The checker watches every cycle for four things. A status bit must not move during a window write that comes with no set or clear input. An edge-mode entry that was just written must show no remote IRR. Every serviceReq and eoiStrobe pulse must trace back to a write of the right kind, and a qualifying EOI write must always produce its pulse. Only the directed scenarios can show the rest: the exact read values of the identification, arbitration and version words, lane-masked merges, the index-to-half mapping at both ends of the table, reads and writes at out-of-range selects, and a 0x11 build ignoring EOI.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;

  localparam logic [7:0] OFF_SEL = 8'h00;
  localparam logic [7:0] OFF_WIN = 8'h10;
  localparam logic [7:0] OFF_EOI = 8'h40;

  localparam logic [7:0] SEL_ID   = 8'h00;
  localparam logic [7:0] SEL_VER  = 8'h01;
  localparam logic [7:0] SEL_ARB  = 8'h02;
  localparam logic [7:0] SEL_TBL  = 8'h10;

  localparam int BIT_PEND   = 12;
  localparam int BIT_REMIRR = 14;
  localparam int BIT_TRIG   = 15;
  localparam int BIT_MASK   = 16;

  localparam logic [63:0] ENTRY_RST = 64'h0000_0000_0001_0000;

  typedef enum logic [1:0] {
    WIN_NONE = 2'd0,
    WIN_IDENT = 2'd1,
    WIN_VERS = 2'd2,
    WIN_ENTRY = 2'd3
  } winKindT;

  typedef struct packed {
    winKindT     kind;
    logic [7:0]  entIdx;
    logic        entHi;
    logic        entWr;
    logic [3:0]  lanes;
    logic [31:0] data;
  } regStrobeT;

endpackage

// File: rtl/irq_redir_ctrl.sv
module irq_redir_ctrl
  import irq_redir_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter logic [7:0] VERSION = 8'h20
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  busAddr,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic [3:0]  byteEn,
  input  logic [31:0] wrData,
  input  logic [31:0] winWord,
  output logic [31:0] rdData,
  output logic [7:0]  selReg,
  output regStrobeT   strb,
  output logic        serviceReq,
  output logic        eoiStrobe,
  output logic [7:0]  eoiVector
);

  localparam logic [7:0] PIN_CNT = 8'(NUM_PINS);
  localparam logic EOI_OK = (VERSION == 8'h20);

  logic [7:0] selOffs;
  logic       selInTbl;
  logic       eoiFire;

  assign selOffs  = selReg - SEL_TBL;
  assign selInTbl = (selReg >= SEL_TBL) && ({1'b0, selOffs[7:1]} < PIN_CNT);

  always_comb begin
    strb.entIdx = {1'b0, selOffs[7:1]};
    strb.entHi  = selOffs[0];
    strb.lanes  = byteEn;
    strb.data   = wrData;
    if (selInTbl)                                 strb.kind = WIN_ENTRY;
    else if (selReg == SEL_ID || selReg == SEL_ARB) strb.kind = WIN_IDENT;
    else if (selReg == SEL_VER)                   strb.kind = WIN_VERS;
    else                                          strb.kind = WIN_NONE;
    strb.entWr = wrEn && (busAddr == OFF_WIN) && selInTbl;
  end

  assign eoiFire = EOI_OK && wrEn && (busAddr == OFF_EOI) && (&byteEn);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selReg     <= '0;
      rdData     <= '0;
      serviceReq <= 1'b0;
      eoiStrobe  <= 1'b0;
      eoiVector  <= '0;
    end else begin
      if (wrEn && busAddr == OFF_SEL && byteEn[0]) selReg <= wrData[7:0];
      if (rdEn) begin
        case (busAddr)
          OFF_SEL: rdData <= {24'h0, selReg};
          OFF_WIN: rdData <= winWord;
          default: rdData <= '0;
        endcase
      end
      serviceReq <= strb.entWr;
      eoiStrobe  <= eoiFire;
      if (eoiFire) eoiVector <= wrData[7:0];
    end
  end

endmodule

// File: rtl/irq_redir_table.sv
module irq_redir_table
  import irq_redir_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter logic [7:0] VERSION = 8'h20
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  regStrobeT             strb,
  input  logic [3:0]            ctrlId,
  input  logic [NUM_PINS-1:0]   pendSet,
  input  logic [NUM_PINS-1:0]   pendClr,
  input  logic [NUM_PINS-1:0]   remIrrSet,
  input  logic [NUM_PINS-1:0]   remIrrClr,
  output logic [31:0]           winWord,
  output logic [64*NUM_PINS-1:0] tableOut
);

  localparam logic [7:0] MAX_ENT = 8'(NUM_PINS - 1);

  logic [63:0] entArr [NUM_PINS];
  logic [31:0] laneMask;
  logic [63:0] wrMask;
  logic [63:0] wrWide;

  assign laneMask = {{8{strb.lanes[3]}}, {8{strb.lanes[2]}},
                     {8{strb.lanes[1]}}, {8{strb.lanes[0]}}};
  assign wrMask = strb.entHi ? {laneMask, 32'h0} : {32'h0, laneMask};
  assign wrWide = {strb.data, strb.data};

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_ent
    logic [63:0] cur;
    logic [63:0] nxt;
    logic        hit;
    logic        pendNxt;
    logic        remNxt;

    assign hit = strb.entWr && (strb.entIdx == 8'(i));

    always_comb begin
      pendNxt = pendSet[i] ? 1'b1 : (pendClr[i] ? 1'b0 : cur[BIT_PEND]);
      remNxt  = remIrrSet[i] ? 1'b1 : (remIrrClr[i] ? 1'b0 : cur[BIT_REMIRR]);
      nxt = cur;
      if (hit) nxt = (cur & ~wrMask) | (wrWide & wrMask);
      nxt[BIT_PEND]   = pendNxt;
      nxt[BIT_REMIRR] = remNxt;
      if (hit && !nxt[BIT_TRIG]) nxt[BIT_REMIRR] = 1'b0;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) cur <= ENTRY_RST;
      else       cur <= nxt;
    end

    assign entArr[i] = cur;
    assign tableOut[64*i +: 64] = cur;
  end

  logic [63:0] selEnt;
  always_comb begin
    selEnt = '0;
    for (int k = 0; k < NUM_PINS; k++) begin
      if (strb.entIdx == 8'(k)) selEnt = entArr[k];
    end
  end

  always_comb begin
    case (strb.kind)
      WIN_IDENT: winWord = {4'h0, ctrlId, 24'h0};
      WIN_VERS:  winWord = {8'h0, MAX_ENT, 8'h0, VERSION};
      WIN_ENTRY: winWord = strb.entHi ? selEnt[63:32] : selEnt[31:0];
      default:   winWord = '0;
    endcase
  end

endmodule

// File: rtl/irq_redir_regif.sv
module irq_redir_regif
  import irq_redir_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter logic [7:0] VERSION = 8'h20
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [7:0]             busAddr,
  input  logic                   wrEn,
  input  logic                   rdEn,
  input  logic [3:0]             byteEn,
  input  logic [31:0]            wrData,
  output logic [31:0]            rdData,
  input  logic [3:0]             ctrlId,
  input  logic [NUM_PINS-1:0]    pendSet,
  input  logic [NUM_PINS-1:0]    pendClr,
  input  logic [NUM_PINS-1:0]    remIrrSet,
  input  logic [NUM_PINS-1:0]    remIrrClr,
  output logic [64*NUM_PINS-1:0] tableOut,
  output logic                   serviceReq,
  output logic                   eoiStrobe,
  output logic [7:0]             eoiVector
);

  regStrobeT   strb;
  logic [31:0] winWord;
  logic [7:0]  selReg;

  irq_redir_ctrl #(.NUM_PINS(NUM_PINS), .VERSION(VERSION)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .wrEn(wrEn), .rdEn(rdEn),
    .byteEn(byteEn), .wrData(wrData), .winWord(winWord), .rdData(rdData),
    .selReg(selReg), .strb(strb), .serviceReq(serviceReq),
    .eoiStrobe(eoiStrobe), .eoiVector(eoiVector)
  );

  irq_redir_table #(.NUM_PINS(NUM_PINS), .VERSION(VERSION)) u_table (
    .clk(clk), .rstN(rstN), .strb(strb), .ctrlId(ctrlId),
    .pendSet(pendSet), .pendClr(pendClr), .remIrrSet(remIrrSet),
    .remIrrClr(remIrrClr), .winWord(winWord), .tableOut(tableOut)
  );

endmodule

// File: rtl/irq_redir_checker.sv
module irq_redir_checker #(
  parameter int NUM_PINS = 24,
  parameter logic [7:0] VERSION = 8'h20
) (
  input logic                   clk,
  input logic                   rstN,
  input logic [7:0]             busAddr,
  input logic                   wrEn,
  input logic [3:0]             byteEn,
  input logic [7:0]             selCur,
  input logic [NUM_PINS-1:0]    pendSet,
  input logic [NUM_PINS-1:0]    pendClr,
  input logic [NUM_PINS-1:0]    remIrrSet,
  input logic [NUM_PINS-1:0]    remIrrClr,
  input logic [64*NUM_PINS-1:0] tableOut,
  input logic                   serviceReq,
  input logic                   eoiStrobe
);

  logic eoiWrite;
  assign eoiWrite = wrEn && (busAddr == 8'h40) && (&byteEn);

  // R9: every service request follows a window write
  a_r9_service_source: assert property (@(posedge clk) disable iff (!rstN)
    serviceReq |-> $past(wrEn && busAddr == 8'h10));

  // R8: every EOI pulse follows a full-word EOI write
  a_r8_eoi_source: assert property (@(posedge clk) disable iff (!rstN)
    eoiStrobe |-> $past(eoiWrite));

  if (VERSION == 8'h20) begin : g_eoi_on
    a_r8_eoi_fires: assert property (@(posedge clk) disable iff (!rstN)
      eoiWrite |=> eoiStrobe);
  end else begin : g_eoi_off
    a_r8_eoi_silent: assert property (@(posedge clk) disable iff (!rstN)
      !eoiStrobe);
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic hitPin;
    logic [7:0] offs;
    assign offs = selCur - 8'h10;
    assign hitPin = wrEn && (busAddr == 8'h10) && (selCur >= 8'h10)
                    && ({1'b0, offs[7:1]} == 8'(i));

    // R6: status bits hold across a write with no set/clear input
    a_r6_status_kept: assert property (@(posedge clk) disable iff (!rstN)
      (hitPin && !pendSet[i] && !pendClr[i]) |=> $stable(tableOut[64*i+12]));

    // R7: an edge-mode entry just written shows no remote IRR
    a_r7_edge_clears: assert property (@(posedge clk) disable iff (!rstN)
      hitPin |=> (tableOut[64*i+15] || !tableOut[64*i+14]));
  end

endmodule

bind irq_redir_regif irq_redir_checker #(.NUM_PINS(NUM_PINS), .VERSION(VERSION)) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .wrEn(wrEn), .byteEn(byteEn),
  .selCur(selReg), .pendSet(pendSet), .pendClr(pendClr),
  .remIrrSet(remIrrSet), .remIrrClr(remIrrClr), .tableOut(tableOut),
  .serviceReq(serviceReq), .eoiStrobe(eoiStrobe)
);

// File: tb/irq_redir_regif_tb.sv
module irq_redir_regif_tb;

  localparam int NP = 24;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] busAddr = '0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [3:0] byteEn = '0;
  logic [31:0] wrData = '0;
  logic [3:0] ctrlId = 4'h5;
  logic [NP-1:0] pendSet = '0, pendClr = '0, remIrrSet = '0, remIrrClr = '0;
  logic [31:0] rdData, oldRd;
  logic [64*NP-1:0] tableOut, oldTable;
  logic serviceReq, eoiStrobe, oldSvc, oldEoi;
  logic [7:0] eoiVector, oldVec;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  irq_redir_regif #(.NUM_PINS(NP), .VERSION(8'h20)) u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .wrEn(wrEn), .rdEn(rdEn),
    .byteEn(byteEn), .wrData(wrData), .rdData(rdData), .ctrlId(ctrlId),
    .pendSet(pendSet), .pendClr(pendClr), .remIrrSet(remIrrSet),
    .remIrrClr(remIrrClr), .tableOut(tableOut), .serviceReq(serviceReq),
    .eoiStrobe(eoiStrobe), .eoiVector(eoiVector)
  );

  irq_redir_regif #(.NUM_PINS(NP), .VERSION(8'h11)) u_old (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .wrEn(wrEn), .rdEn(rdEn),
    .byteEn(byteEn), .wrData(wrData), .rdData(oldRd), .ctrlId(ctrlId),
    .pendSet(pendSet), .pendClr(pendClr), .remIrrSet(remIrrSet),
    .remIrrClr(remIrrClr), .tableOut(oldTable), .serviceReq(oldSvc),
    .eoiStrobe(oldEoi), .eoiVector(oldVec)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    busAddr = a; wrData = d; byteEn = be; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; byteEn = '0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d, output logic [31:0] dOld);
    @(negedge clk);
    busAddr = a; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData; dOld = oldRd;
  endtask

  task automatic selRead(input logic [7:0] s, output logic [31:0] d);
    logic [31:0] dOld;
    busWrite(8'h00, {24'h0, s}, 4'hF);
    busRead(8'h10, d, dOld);
  endtask

  task automatic t_reset;
    logic [31:0] d, dOld;
    check("R10 entry0 reset", tableOut[31:0], 32'h0001_0000);
    check("R10 entry0 hi reset", tableOut[63:32], 32'h0);
    check("R10 entry23 reset", tableOut[64*23 +: 32], 32'h0001_0000);
    busRead(8'h00, d, dOld);
    check("R2 select reset", d, 32'h0);
  endtask

  task automatic t_ident;
    logic [31:0] d, dOld;
    busWrite(8'h00, 32'hFFFF_FF01, 4'h1);
    busRead(8'h00, d, dOld);
    check("R2 select readback", d, 32'h0000_0001);
    busRead(8'h10, d, dOld);
    check("R4 version 0x20", d, 32'h0017_0020);
    check("R4 version 0x11", dOld, 32'h0017_0011);
    selRead(8'h00, d);
    check("R3 id word", d, 32'h0500_0000);
    selRead(8'h02, d);
    check("R3 arbitration word", d, 32'h0500_0000);
    busRead(8'h40, d, dOld);
    check("R1 eoi reads zero", d, 32'h0);
    busRead(8'h20, d, dOld);
    check("R1 unmapped offset zero", d, 32'h0);
  endtask

  task automatic t_table;
    logic [31:0] d;
    busWrite(8'h00, 32'h16, 4'hF);
    check("R9 no request on select write", {31'h0, serviceReq}, 32'h0);
    busWrite(8'h10, 32'h0000_A031, 4'hF);
    check("R9 request after entry write", {31'h0, serviceReq}, 32'h1);
    @(negedge clk);
    check("R9 request is one cycle", {31'h0, serviceReq}, 32'h0);
    busWrite(8'h00, 32'h17, 4'hF);
    busWrite(8'h10, 32'hFF00_0000, 4'hF);
    check("R5 entry3 flat", tableOut[64*3 +: 32], 32'h0000_A031);
    check("R5 entry3 flat hi", tableOut[64*3+32 +: 32], 32'hFF00_0000);
    selRead(8'h16, d);
    check("R5 entry3 lo read", d, 32'h0000_A031);
    busWrite(8'h10, 32'hFFFF_FF77, 4'h1);
    selRead(8'h16, d);
    check("R5 lane 0 only merge", d, 32'h0000_A077);
  endtask

  task automatic pulse(input int pin, input bit pend, input bit rem);
    @(negedge clk);
    pendSet[pin] = pend; remIrrSet[pin] = rem;
    @(negedge clk);
    pendSet = '0; remIrrSet = '0;
  endtask

  task automatic t_status;
    logic [31:0] d;
    busWrite(8'h00, 32'h18, 4'hF);
    busWrite(8'h10, 32'h0000_8040, 4'hF);
    pulse(4, 1'b1, 1'b1);
    check("R6 status set by inputs", tableOut[64*4 +: 32], 32'h0000_D040);
    busWrite(8'h10, 32'h0000_8041, 4'hF);
    selRead(8'h18, d);
    check("R6 status kept across write", d, 32'h0000_D041);
    busWrite(8'h00, 32'h1A, 4'hF);
    busWrite(8'h10, 32'h0000_D000, 4'hF);
    check("R6 status not writable", tableOut[64*5 +: 32], 32'h0000_8000);
  endtask

  task automatic t_edge;
    logic [31:0] d;
    busWrite(8'h00, 32'h18, 4'hF);
    busWrite(8'h10, 32'h0000_0041, 4'hF);
    selRead(8'h18, d);
    check("R7 edge clears remote IRR", d, 32'h0000_1041);
    busWrite(8'h00, 32'h1C, 4'hF);
    busWrite(8'h10, 32'h0000_8000, 4'hF);
    pulse(6, 1'b0, 1'b1);
    busWrite(8'h00, 32'h1D, 4'hF);
    busWrite(8'h10, 32'h1200_0000, 4'hF);
    check("R7 level keeps remote IRR", tableOut[64*6 +: 32], 32'h0000_C000);
  endtask

  task automatic t_range;
    logic [31:0] d;
    logic [64*NP-1:0] snap;
    busWrite(8'h00, 32'h40, 4'hF);
    snap = tableOut;
    busWrite(8'h10, 32'hFFFF_FFFF, 4'hF);
    check("R11 no request out of range", {31'h0, serviceReq}, 32'h0);
    check("R11 table untouched", {31'h0, tableOut == snap}, 32'h1);
    selRead(8'h40, d);
    check("R11 index 24 reads zero", d, 32'h0);
    selRead(8'h0F, d);
    check("R11 select 0x0F reads zero", d, 32'h0);
    busWrite(8'h00, 32'h3F, 4'hF);
    busWrite(8'h10, 32'hAB00_0000, 4'hF);
    selRead(8'h3F, d);
    check("R5 last entry hi", d, 32'hAB00_0000);
  endtask

  task automatic t_eoi;
    busWrite(8'h40, 32'h0000_00C5, 4'hF);
    check("R8 eoi strobe", {31'h0, eoiStrobe}, 32'h1);
    check("R8 eoi vector", {24'h0, eoiVector}, 32'hC5);
    check("R8 version 0x11 ignores eoi", {31'h0, oldEoi}, 32'h0);
    @(negedge clk);
    check("R8 eoi one cycle", {31'h0, eoiStrobe}, 32'h0);
    busWrite(8'h40, 32'h0000_0033, 4'h3);
    check("R8 partial eoi ignored", {31'h0, eoiStrobe}, 32'h0);
    busWrite(8'h44, 32'h0000_0033, 4'hF);
    check("R1 wrong offset no eoi", {31'h0, eoiStrobe}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_ident();
    t_table();
    t_status();
    t_edge();
    t_range();
    t_eoi();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule